// File: doc/BRIEF.md
# Audio Serial Bit Clock and Frame Sync Generator

This block is the timing master for a serial audio port. It makes a codec master clock, a bit clock and a frame sync from one selectable source. The source is either the internal reference or an external high-frequency clock pin. Two integer dividers sit in cascade. The first divides the source into the high-frequency master clock. The second divides that clock into the bit clock. A frame counter then counts bit clocks over a frame built from a programmable number of slots of a programmable width. It raises a frame sync that is exactly one bit wide and coincides with the first data bit (no one-bit delay).

Everything runs in the system clock domain. The internal reference is the system clock divided by two: every system cycle is one reference half-period, so a 48 MHz system clock gives a 24 MHz reference. Only integer ratios of 24 MHz are reachable from the reference. For exact 44.1 kHz or 48 kHz family rates, the external pin is selected. It is synchronised, and each of its edges counts as one source half-period. Configuration is copied into shadow registers while the block is disabled and at each frame start. A change made mid-frame therefore never cuts a clock phase short.

Top module: `audclk_gen`

## Requirements
- R1: With the internal source, one bit clock period lasts 2·D1·D2 system cycles. D1 = high-frequency field + 1 (12-bit field) and D2 = bit clock field + 1 (5-bit field).
- R2: The master clock output toggles once every D1 source edges. With the internal source its period is 2·D1 system cycles, and a high-frequency field of 0 passes the source rate straight through.
- R3: With the source select at 1, both edges of the synchronised external pin are source edges. With both fields at 0, the bit clock and master clock periods equal the pin period.
- R4: Frame length in bits is slots × slot width. Slots = slot field + 1 (1 to 32). Width = width field + 1, with width field values 0 to 6 treated as 8 bits, so the width runs 8 to 32.
- R5: Frame sync is high for exactly the first bit period of each frame. It changes on the same system edge as the active (rising, when not inverted) bit clock edge that starts that bit.
- R6: With the invert bit set, the bit clock is inverted, its idle level is high, and frame sync keeps active-high polarity and the same timing.
- R7: Configuration written while running takes effect at the next frame start. The remaining bits of the current frame keep the old period, and every bit of the next frame uses the new period and length.
- R8: Within one system cycle after enable falls, the bit clock is at its idle level and frame sync and the master clock are low. Each restart begins a new frame, with frame sync on the first bit.
- R9: After reset, the bit clock, master clock and frame sync are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the internal reference is this clock divided by two |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the generator; low holds all outputs idle |
| srcSel | input | 1 | 0 = internal reference, 1 = external pin |
| extClk | input | 1 | External high-frequency clock pin (asynchronous) |
| hfDivSel | input | 12 | High-frequency divider field, divides by value + 1 |
| bitDivSel | input | 5 | Bit clock divider field, divides by value + 1 |
| slotCountSel | input | 5 | Slots per frame minus one |
| slotWidthSel | input | 5 | Bits per slot minus one, minimum 8 bits |
| invertBclk | input | 1 | Invert the bit clock |
| mclkOut | output | 1 | Divided high-frequency (codec master) clock |
| bitClk | output | 1 | Serial bit clock |
| frameSync | output | 1 | One-bit-wide frame sync pulse |

## Verification
Three events can fall in the same system cycle: the frame-start load of new divider and frame settings, the wrap of both divider counters, and the bit clock edge itself. The bench makes them coincide by rewriting dividers and slot settings a few bits into a running frame. It then checks, bit by bit, that the last old bit keeps the old period and that the first new bit already has the new period. It also checks that the next frame sync appears after the new frame length. Restarting after disable is judged the same way, by the frame sync on the first bit.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  // strobes from the framer (control) to the divider chain (datapath)
  typedef struct packed {
    logic run;
    logic clear;
  } ctlStrobes_t;

  // events reported by the divider chain back to the framer
  typedef struct packed {
    logic hfEdge;
    logic bitToggle;
    logic bitRise;
  } dpEvents_t;

endpackage

// File: rtl/audclk_divchain.sv
module audclk_divchain
  import audclk_pkg::*;
#(
  parameter int HF_SEL_W    = 12,
  parameter int BIT_SEL_W   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctlStrobes_t          ctl,
  input  logic                 srcSelQ,
  input  logic                 extClk,
  input  logic [HF_SEL_W-1:0]  hfLim,
  input  logic [BIT_SEL_W-1:0] bitLim,
  output dpEvents_t            ev,
  output logic                 mclkQ,
  output logic                 phaseQ
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0]    extSync;
  logic                 extPrev;
  logic                 srcEdge;
  logic [HF_SEL_W-1:0]  hfCnt;
  logic [BIT_SEL_W-1:0] bitCnt;
  logic                 hfWrap;
  logic                 bitWrap;

  // external pin synchroniser, one flop per stage
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) extSync[s] <= 1'b0;
          else     extSync[s] <= extClk;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (rst) extSync[s] <= 1'b0;
          else     extSync[s] <= extSync[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) extPrev <= 1'b0;
    else     extPrev <= extSync[SYNC_MSB];
  end

  // every system cycle is one internal reference half-period;
  // every pin transition is one external half-period
  always_comb begin
    if (srcSelQ) srcEdge = extSync[SYNC_MSB] ^ extPrev;
    else         srcEdge = 1'b1;
  end

  assign hfWrap  = (hfCnt == hfLim);
  assign bitWrap = (bitCnt == bitLim);

  always_comb begin
    ev.hfEdge    = ctl.run && srcEdge && hfWrap;
    ev.bitToggle = ev.hfEdge && bitWrap;
    ev.bitRise   = ev.bitToggle && !phaseQ;
  end

  // first stage: high-frequency divider
  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      hfCnt <= '0;
      mclkQ <= 1'b0;
    end else if (ctl.run && srcEdge) begin
      if (hfWrap) begin
        hfCnt <= '0;
        mclkQ <= ~mclkQ;
      end else begin
        hfCnt <= hfCnt + 1'b1;
      end
    end
  end

  // second stage: bit clock divider
  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      bitCnt <= '0;
      phaseQ <= 1'b0;
    end else if (ev.hfEdge) begin
      if (bitWrap) begin
        bitCnt <= '0;
        phaseQ <= ~phaseQ;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    hfCnt <= hfLim);

  // R1
  bit_count_range_chk: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= bitLim);

  // R1
  phase_only_on_hf_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.run && !ev.hfEdge) |=> (phaseQ == $past(phaseQ)));

endmodule

// File: rtl/audclk_framer.sv
module audclk_framer
  import audclk_pkg::*;
#(
  parameter int HF_SEL_W      = 12,
  parameter int BIT_SEL_W     = 5,
  parameter int SLOT_SEL_W    = 5,
  parameter int WIDTH_SEL_W   = 5,
  parameter int MIN_SLOT_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enable,
  input  logic                   srcSel,
  input  logic [HF_SEL_W-1:0]    hfDivSel,
  input  logic [BIT_SEL_W-1:0]   bitDivSel,
  input  logic [SLOT_SEL_W-1:0]  slotCountSel,
  input  logic [WIDTH_SEL_W-1:0] slotWidthSel,
  input  logic                   invertBclk,
  input  dpEvents_t              ev,
  output ctlStrobes_t            ctl,
  output logic                   srcSelQ,
  output logic                   invQ,
  output logic [HF_SEL_W-1:0]    hfLimQ,
  output logic [BIT_SEL_W-1:0]   bitLimQ,
  output logic                   frameSync
);

  localparam int POS_W = SLOT_SEL_W + WIDTH_SEL_W + 2;
  localparam logic [WIDTH_SEL_W-1:0] WIDTH_FLOOR = WIDTH_SEL_W'(MIN_SLOT_BITS - 1);

  logic [SLOT_SEL_W-1:0]  slotsQ;
  logic [WIDTH_SEL_W-1:0] widthQ;
  logic [SLOT_SEL_W:0]    slotNum;
  logic [WIDTH_SEL_W:0]   bitsPerSlot;
  logic [POS_W-1:0]       frameLen;
  logic [POS_W-1:0]       posLast;
  logic [POS_W-1:0]       posCnt;
  logic                   frameLoad;

  always_comb begin
    ctl.run   = enable;
    ctl.clear = !enable;
  end

  assign frameLoad = ev.bitRise && (posCnt == '0);

  // shadow configuration: follows inputs while idle, latched per frame
  always_ff @(posedge clk) begin
    if (rst) begin
      srcSelQ <= 1'b0;
      invQ    <= 1'b0;
      hfLimQ  <= '0;
      bitLimQ <= '0;
      slotsQ  <= '0;
      widthQ  <= '0;
    end else if (!enable || frameLoad) begin
      srcSelQ <= srcSel;
      invQ    <= invertBclk;
      hfLimQ  <= hfDivSel;
      bitLimQ <= bitDivSel;
      slotsQ  <= slotCountSel;
      widthQ  <= slotWidthSel;
    end
  end

  always_comb begin
    slotNum = {1'b0, slotsQ} + 1'b1;
    if (widthQ < WIDTH_FLOOR) bitsPerSlot = (WIDTH_SEL_W+1)'(MIN_SLOT_BITS);
    else                      bitsPerSlot = {1'b0, widthQ} + 1'b1;
    frameLen = POS_W'(slotNum) * POS_W'(bitsPerSlot);
    posLast  = frameLen - POS_W'(1);
  end

  // frame position counts bit starts; sync marks the first bit
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      posCnt    <= '0;
      frameSync <= 1'b0;
    end else if (ev.bitRise) begin
      frameSync <= (posCnt == '0);
      if (posCnt == posLast) posCnt <= '0;
      else                   posCnt <= posCnt + 1'b1;
    end
  end

  // R5
  sync_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && frameSync && ev.bitRise) |=> !frameSync);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !frameLoad) |=> (hfLimQ == $past(hfLimQ) && bitLimQ == $past(bitLimQ)));

  // R8
  idle_sync_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !frameSync);

  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    posCnt <= posLast);

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
#(
  parameter int HF_SEL_W      = 12,
  parameter int BIT_SEL_W     = 5,
  parameter int SLOT_SEL_W    = 5,
  parameter int WIDTH_SEL_W   = 5,
  parameter int MIN_SLOT_BITS = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enable,
  input  logic                   srcSel,
  input  logic                   extClk,
  input  logic [HF_SEL_W-1:0]    hfDivSel,
  input  logic [BIT_SEL_W-1:0]   bitDivSel,
  input  logic [SLOT_SEL_W-1:0]  slotCountSel,
  input  logic [WIDTH_SEL_W-1:0] slotWidthSel,
  input  logic                   invertBclk,
  output logic                   mclkOut,
  output logic                   bitClk,
  output logic                   frameSync
);

  ctlStrobes_t          ctl;
  dpEvents_t            ev;
  logic                 srcSelQ;
  logic                 invQ;
  logic [HF_SEL_W-1:0]  hfLimQ;
  logic [BIT_SEL_W-1:0] bitLimQ;
  logic                 phaseQ;

  audclk_framer #(
    .HF_SEL_W(HF_SEL_W), .BIT_SEL_W(BIT_SEL_W), .SLOT_SEL_W(SLOT_SEL_W),
    .WIDTH_SEL_W(WIDTH_SEL_W), .MIN_SLOT_BITS(MIN_SLOT_BITS)
  ) uFramer (
    .clk(clk), .rst(rst), .enable(enable), .srcSel(srcSel),
    .hfDivSel(hfDivSel), .bitDivSel(bitDivSel),
    .slotCountSel(slotCountSel), .slotWidthSel(slotWidthSel),
    .invertBclk(invertBclk), .ev(ev), .ctl(ctl),
    .srcSelQ(srcSelQ), .invQ(invQ), .hfLimQ(hfLimQ), .bitLimQ(bitLimQ),
    .frameSync(frameSync)
  );

  audclk_divchain #(
    .HF_SEL_W(HF_SEL_W), .BIT_SEL_W(BIT_SEL_W), .SYNC_STAGES(SYNC_STAGES)
  ) uChain (
    .clk(clk), .rst(rst), .ctl(ctl), .srcSelQ(srcSelQ), .extClk(extClk),
    .hfLim(hfLimQ), .bitLim(bitLimQ), .ev(ev), .mclkQ(mclkOut), .phaseQ(phaseQ)
  );

  assign bitClk = phaseQ ^ invQ;

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && !ctl.run) |=> (bitClk == invQ));

endmodule

// File: tb/audclk_gen_test.sv
module audclk_gen_test;
  import audclk_pkg::*;

  typedef struct {
    int    period;
    bit    fs;
    string tag;
  } item_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        srcSel = 1'b0;
  logic        extClk = 1'b0;
  logic [11:0] hfDivSel = '0;
  logic [4:0]  bitDivSel = '0;
  logic [4:0]  slotCountSel = '0;
  logic [4:0]  slotWidthSel = '0;
  logic        invertBclk = 1'b0;
  logic        mclkOut;
  logic        bitClk;
  logic        frameSync;

  audclk_gen uut (
    .clk(clk), .rst(rst), .enable(enable), .srcSel(srcSel), .extClk(extClk),
    .hfDivSel(hfDivSel), .bitDivSel(bitDivSel), .slotCountSel(slotCountSel),
    .slotWidthSel(slotWidthSel), .invertBclk(invertBclk),
    .mclkOut(mclkOut), .bitClk(bitClk), .frameSync(frameSync)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  item_t q[$];
  bit    monOn = 0;
  bit    invB = 0;
  bit    extOn = 0;
  int    negCount = 0;
  int    lastRise = -1;
  bit    prevS = 0;
  bit    curS;
  int    posCount = 0;

  task automatic checkIt(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void pushFrame(input int firstPer, input int per, input int len, input string tag);
    item_t it;
    for (int i = 0; i < len; i++) begin
      it.period = (i == 0) ? firstPer : per;
      it.fs     = (i == 0);
      it.tag    = tag;
      q.push_back(it);
    end
  endfunction

  function automatic void pushBit(input int per, input bit fs, input string tag);
    item_t it;
    it.period = per; it.fs = fs; it.tag = tag;
    q.push_back(it);
  endfunction

  // scoreboard monitor: one item per active bit clock edge
  always @(negedge clk) begin
    item_t it;
    int per;
    negCount++;
    curS = bitClk ^ invB;
    if (!monOn) begin
      lastRise = -1;
    end else if (curS && !prevS) begin
      per = (lastRise < 0) ? -1 : negCount - lastRise;
      lastRise = negCount;
      if (q.size() == 0) begin
        checkIt(0, "R5 unexpected bit", per, 0);
      end else begin
        it = q.pop_front();
        if (it.period >= 0)
          checkIt(per == it.period, {it.tag, " period"}, per, it.period);
        checkIt(frameSync == it.fs, {it.tag, " sync"}, int'(frameSync), int'(it.fs));
      end
    end
    prevS = curS;
  end

  // external pin: one transition every 3 system cycles
  initial begin
    forever begin
      repeat (3) @(posedge clk);
      if (extOn) begin
        #2;
        extClk = ~extClk;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    posCount++;
    if (posCount == 150000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", posCount, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setCfg(input int hf, input int bd, input int sc, input int sw,
                        input bit src, input bit inv);
    hfDivSel     = 12'(hf);
    bitDivSel    = 5'(bd);
    slotCountSel = 5'(sc);
    slotWidthSel = 5'(sw);
    srcSel       = src;
    invertBclk   = inv;
  endtask

  task automatic startRun();
    tick();
    monOn  = 1;
    enable = 1'b1;
  endtask

  task automatic drainAndStop(input string tag);
    int n = 0;
    while (q.size() > 0 && n < 20000) begin
      tick();
      n++;
    end
    checkIt(q.size() == 0, {tag, " items left"}, q.size(), 0);
    q.delete();
    monOn  = 0;
    enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R8 idle within one cycle after enable falls
    checkIt(bitClk == invB, "R8 idle bit clock", int'(bitClk), int'(invB));
    checkIt(frameSync == 1'b0, "R8 idle sync", int'(frameSync), 0);
    checkIt(mclkOut == 1'b0, "R8 idle master clock", int'(mclkOut), 0);
    tick();
  endtask

  task automatic measureMclk(input int expPer, input string tag);
    int t0 = -1;
    bit pv;
    @(negedge clk);
    pv = mclkOut;
    for (int k = 0; k < 4; k++) begin
      int guard = 0;
      while (guard < 1000) begin
        @(negedge clk);
        guard++;
        if (mclkOut && !pv) begin
          pv = mclkOut;
          break;
        end
        pv = mclkOut;
      end
      if (t0 >= 0) checkIt(negCount - t0 == expPer, tag, negCount - t0, expPer);
      t0 = negCount;
    end
  endtask

  initial begin
    repeat (5) tick();
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    checkIt(bitClk == 1'b0, "R9 bit clock after reset", int'(bitClk), 0);
    checkIt(mclkOut == 1'b0, "R9 master clock after reset", int'(mclkOut), 0);
    checkIt(frameSync == 1'b0, "R9 sync after reset", int'(frameSync), 0);

    // R1 R5: internal, D1=1 D2=2, 2x8 bits, period 4
    setCfg(0, 1, 1, 7, 0, 0);
    pushFrame(-1, 4, 16, "R1 R5 short");
    pushFrame(4, 4, 16, "R1 R5 short");
    pushBit(4, 1, "R5 short wrap");
    startRun();
    drainAndStop("R1");

    // R1 R2: D1=3 D2=16, period 96, master clock period 6
    setCfg(2, 15, 1, 7, 0, 0);
    pushFrame(-1, 96, 16, "R1 long");
    pushBit(96, 1, "R1 long wrap");
    startRun();
    measureMclk(6, "R2 master clock period");
    drainAndStop("R1 long");

    // R6: inverted bit clock, D1=2 D2=1, period 4
    setCfg(1, 0, 1, 7, 0, 1);
    invB = 1;
    repeat (3) tick();
    @(negedge clk);
    checkIt(bitClk == 1'b1, "R6 inverted idle", int'(bitClk), 1);
    pushFrame(-1, 4, 16, "R6 inverted");
    pushBit(4, 1, "R6 inverted wrap");
    startRun();
    drainAndStop("R6");
    setCfg(1, 0, 1, 7, 0, 0);
    invB = 0;
    repeat (3) tick();

    // R7 R4: change mid-frame to D2=4, 3 slots, width field 3 (clamped to 8)
    setCfg(0, 1, 1, 7, 0, 0);
    pushFrame(-1, 4, 16, "R7 old frame");
    pushFrame(4, 8, 24, "R7 new frame");
    pushBit(8, 1, "R4 clamped length");
    startRun();
    repeat (12) tick();
    setCfg(0, 3, 2, 3, 0, 0);
    drainAndStop("R7");

    // R4: 32 slots of 8 bits, period 2
    setCfg(0, 0, 31, 7, 0, 0);
    pushFrame(-1, 2, 256, "R4 wide frame");
    pushBit(2, 1, "R4 wide wrap");
    startRun();
    drainAndStop("R4");

    // R3: external pin, pass-through dividers, 2x32 bits
    extOn = 1;
    setCfg(0, 0, 1, 31, 1, 0);
    repeat (10) tick();
    pushFrame(-1, 6, 64, "R3 external");
    pushBit(6, 1, "R3 external wrap");
    startRun();
    measureMclk(6, "R3 master clock period");
    drainAndStop("R3");
    extOn = 0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule